// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block is the first stage of a memory management unit. It splits the 32-bit virtual address space into sixteen segments of 256 MB each, chosen by the top four address bits. Each segment is configured as one of two kinds:

- A **linear** segment swaps its top nibble for a programmed 4-bit physical base and keeps the lower 28 bits as they are.
- A **paged** segment is passed on to a separate page-translation stage, which works on 8 KB pages.

A privilege check rejects user-mode accesses to the upper segments. This keeps the kernel-only windows, such as register and flash apertures, out of reach of user code.

Software programs three configuration words through a simple write port:

- a per-segment mode mask;
- a base word for the lower eight segments;
- a base word for the upper eight segments.

Requests arrive with a valid/ready handshake. The result comes out one cycle after a request is accepted. It carries one of three outcomes:

- a physical address, for a linear hit;
- a paging request with the virtual page number, for a paged hit;
- an access fault.

After reset every segment is linear with a base equal to its own index, so translation starts as an identity map. Code can keep running while software reshapes the map, for example by leaving segment 4 linear with base 4.

Top module: `seg_xlate_top`

## Requirements
- R1: While `rstN` is low, `rspValid` and `reqReady` are 0. After reset, `reqReady` is 1 and every segment is linear with base equal to its index, so a kernel request's `rspPaddr` equals its virtual address.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. Its result appears with `rspValid`=1 after that same edge. `rspValid` is 0 after every edge with no acceptance. Back-to-back requests give back-to-back results in order.
- R3: For a linear segment with no fault, `rspPaddr` = {base of segment, virtual bits 27:0}. In that case `rspPageReq`=0 and `rspFault`=0.
- R4: A request with `reqUser`=1 and top nibble 0xB or above gives `rspFault`=1, `rspPageReq`=0 and `rspPaddr`=0, whatever the segment's mode.
- R5: For a segment whose mode bit is 1 (paged) and with no fault:
  - `rspPageReq`=1;
  - `rspPaddr`=0;
  - `rspPageNum` = virtual bits 31:13 (8 KB pages).
- R6: Configuration writes are decoded from `cfgSel` when `cfgWrEn`=1:
  - `cfgSel`=0 loads the mode mask from `cfgData[15:0]`; bit i=1 makes segment i paged.
  - `cfgSel`=1 loads the bases of segments 0..7; segment i's base is at `cfgData[4i+3:4i]`.
  - `cfgSel`=2 loads the bases of segments 8..15; segment 8+i's base is at `cfgData[4i+3:4i]`.
- R7: A configuration write applies to requests accepted on later edges. A request accepted on the same edge as the write is translated with the old configuration.
- R8: A request with `reqUser`=0 never faults; all 16 segments are reachable in kernel mode.
- R9: `rspVaddr` echoes the accepted virtual address on every result. `rspPageNum` is 0 whenever `rspPageReq` is 0.
- R10: A write with `cfgSel`=3 changes no mode bit and no base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration word select (0 mode, 1 low bases, 2 high bases, 3 none) |
| cfgData | input | 32 | Configuration write data |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqVaddr | input | 32 | Virtual address of the request |
| reqUser | input | 1 | 1 for a user-mode access, 0 for kernel mode |
| rspValid | output | 1 | Result valid, one cycle after acceptance |
| rspPaddr | output | 32 | Physical address for a linear hit, else 0 |
| rspVaddr | output | 32 | Echo of the accepted virtual address |
| rspPageNum | output | 19 | Virtual page number for a paged hit, else 0 |
| rspPageReq | output | 1 | Result must go to the page-translation stage |
| rspFault | output | 1 | User-mode access to a kernel-only segment |

## Verification
The properties assume a few things about the environment:

- `reqVaddr` and `reqUser` are stable and defined whenever `reqValid` is high.
- Configuration and request inputs change only between clock edges.
- The consumer takes every result in the cycle it appears, since the output side has no backpressure.

The stimulus drives every input on the falling edge and holds it for a full cycle. It checks results on the following falling edge. The one deliberate overlap is a configuration write and a request on the same edge, which is driven to exercise the ordering rule of R7.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Selector values on the configuration write port.
  typedef enum logic [1:0] {
    CFG_MODE    = 2'd0,
    CFG_BASE_LO = 2'd1,
    CFG_BASE_HI = 2'd2,
    CFG_RSVD    = 2'd3
  } cfgSel_e;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic wrMode;
    logic wrBaseLo;
    logic wrBaseHi;
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic        reqValid,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  logic rdyQ;

  // Ready rises on the first edge after reset is released.
  always_ff @(posedge clk) begin
    if (!rstN) rdyQ <= 1'b0;
    else       rdyQ <= 1'b1;
  end

  assign reqReady = rdyQ;

  always_comb begin
    strobe          = '0;
    strobe.wrMode   = cfgWrEn && (cfgSel == CFG_MODE);
    strobe.wrBaseLo = cfgWrEn && (cfgSel == CFG_BASE_LO);
    strobe.wrBaseHi = cfgWrEn && (cfgSel == CFG_BASE_HI);
    strobe.capture  = reqValid && rdyQ;
  end

  AST_CFG_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMode, strobe.wrBaseLo, strobe.wrBaseHi})); // R6

  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == CFG_RSVD) |-> !(strobe.wrMode || strobe.wrBaseLo || strobe.wrBaseHi)); // R10

endmodule

// File: rtl/seg_xlate_datapath.sv
module seg_xlate_datapath
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int PAGE_BITS      = 13,
  parameter int DATA_W         = 32,
  parameter int USER_SEG_LIMIT = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [DATA_W-1:0]         cfgData,
  input  logic [ADDR_W-1:0]         reqVaddr,
  input  logic                      reqUser,
  output logic                      rspValid,
  output logic [ADDR_W-1:0]         rspPaddr,
  output logic [ADDR_W-1:0]         rspVaddr,
  output logic [ADDR_W-PAGE_BITS-1:0] rspPageNum,
  output logic                      rspPageReq,
  output logic                      rspFault
);

  localparam int NUM_SEG      = 2 ** SEG_BITS;
  localparam int OFF_W        = ADDR_W - SEG_BITS;
  localparam int SEG_PER_WORD = DATA_W / SEG_BITS;
  localparam int VPN_W        = ADDR_W - PAGE_BITS;

  logic [NUM_SEG-1:0]  pagedQ;
  logic [SEG_BITS-1:0] baseQ [NUM_SEG];

  // Mode mask: a 1 marks the segment as paged.
  always_ff @(posedge clk) begin
    if (!rstN)              pagedQ <= '0;
    else if (strobe.wrMode) pagedQ <= cfgData[NUM_SEG-1:0];
  end

  // One base register per segment; its word and nibble position follow from the index.
  for (genvar g = 0; g < NUM_SEG; g++) begin : gSegBase
    localparam int  LOC   = g % SEG_PER_WORD;
    localparam bit  IS_HI = (g >= SEG_PER_WORD);
    always_ff @(posedge clk) begin
      if (!rstN)
        baseQ[g] <= SEG_BITS'(g);
      else if ((IS_HI && strobe.wrBaseHi) || (!IS_HI && strobe.wrBaseLo))
        baseQ[g] <= cfgData[LOC*SEG_BITS +: SEG_BITS];
    end
  end

  logic [SEG_BITS-1:0] segIdx;
  logic                isFault;
  logic                isPaged;
  logic [ADDR_W-1:0]   linAddr;

  always_comb begin
    segIdx  = reqVaddr[ADDR_W-1 -: SEG_BITS];
    isFault = reqUser && (segIdx >= SEG_BITS'(USER_SEG_LIMIT));
    isPaged = !isFault && pagedQ[segIdx];
    linAddr = {baseQ[segIdx], reqVaddr[OFF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspPaddr   <= '0;
      rspVaddr   <= '0;
      rspPageNum <= '0;
      rspPageReq <= 1'b0;
      rspFault   <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspVaddr   <= reqVaddr;
        rspFault   <= isFault;
        rspPageReq <= isPaged;
        rspPaddr   <= (isFault || isPaged) ? '0 : linAddr;
        rspPageNum <= isPaged ? reqVaddr[ADDR_W-1:PAGE_BITS] : VPN_W'(0);
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !rspValid); // R2

  AST_LINEAR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault && !rspPageReq) |-> (rspPaddr[OFF_W-1:0] == rspVaddr[OFF_W-1:0])); // R3

  AST_USER_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqUser && (reqVaddr[ADDR_W-1 -: SEG_BITS] >= SEG_BITS'(USER_SEG_LIMIT)))
      |=> (rspFault && !rspPageReq && rspPaddr == '0)); // R4

  AST_PAGED_NO_PADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspPageReq) |-> (rspPaddr == '0 && !rspFault)); // R5

  AST_KERNEL_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !reqUser) |=> !rspFault); // R8

  AST_VPN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspPageReq) |-> (rspPageNum == '0)); // R9

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int PAGE_BITS      = 13,
  parameter int DATA_W         = 32,
  parameter int USER_SEG_LIMIT = 11
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [1:0]                  cfgSel,
  input  logic [DATA_W-1:0]           cfgData,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [ADDR_W-1:0]           reqVaddr,
  input  logic                        reqUser,
  output logic                        rspValid,
  output logic [ADDR_W-1:0]           rspPaddr,
  output logic [ADDR_W-1:0]           rspVaddr,
  output logic [ADDR_W-PAGE_BITS-1:0] rspPageNum,
  output logic                        rspPageReq,
  output logic                        rspFault
);

  ctrlStrobe_t strobe;

  seg_xlate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  seg_xlate_datapath #(
    .ADDR_W         (ADDR_W),
    .SEG_BITS       (SEG_BITS),
    .PAGE_BITS      (PAGE_BITS),
    .DATA_W         (DATA_W),
    .USER_SEG_LIMIT (USER_SEG_LIMIT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgData    (cfgData),
    .reqVaddr   (reqVaddr),
    .reqUser    (reqUser),
    .rspValid   (rspValid),
    .rspPaddr   (rspPaddr),
    .rspVaddr   (rspVaddr),
    .rspPageNum (rspPageNum),
    .rspPageReq (rspPageReq),
    .rspFault   (rspFault)
  );

endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqUser = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [31:0] rspVaddr;
  logic [18:0] rspPageNum;
  logic        rspPageReq;
  logic        rspFault;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqUser(reqUser),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspVaddr(rspVaddr),
    .rspPageNum(rspPageNum), .rspPageReq(rspPageReq), .rspFault(rspFault)
  );

  typedef struct {
    logic [31:0] paddr;
    logic [31:0] vaddr;
    logic [18:0] pnum;
    logic        pg;
    logic        flt;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t mItem;

  // Reference configuration state
  logic [15:0] mdlPaged = '0;
  logic [3:0]  mdlBase [16];

  initial for (int i = 0; i < 16; i++) mdlBase[i] = 4'(i);

  function automatic expItem_t predict(input logic [31:0] va, input logic usr, input string tag);
    expItem_t e;
    logic [3:0] s;
    s       = va[31:28];
    e.flt   = usr && (s >= 4'hB);
    e.pg    = !e.flt && mdlPaged[s];
    e.paddr = (e.flt || e.pg) ? 32'h0 : {mdlBase[s], va[27:0]};
    e.pnum  = e.pg ? va[31:13] : 19'h0;
    e.vaddr = va;
    e.tag   = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic void mdlWrite(input logic [1:0] sel, input logic [31:0] d);
    case (sel)
      2'd0: mdlPaged = d[15:0];
      2'd1: for (int i = 0; i < 8; i++) mdlBase[i]     = d[4*i +: 4];
      2'd2: for (int i = 0; i < 8; i++) mdlBase[8 + i] = d[4*i +: 4];
      default: ;
    endcase
  endfunction

  // All driver tasks start and end on a falling edge.
  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mdlWrite(sel, d);
  endtask

  task automatic sendReq(input logic [31:0] va, input logic usr, input string tag);
    reqValid = 1'b1; reqVaddr = va; reqUser = usr;
    expQ.push_back(predict(va, usr, tag));
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  // R7: write and request share one edge; request sees the old configuration.
  task automatic cfgAndReq(input logic [1:0] sel, input logic [31:0] d,
                           input logic [31:0] va, input logic usr, input string tag);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    reqValid = 1'b1; reqVaddr = va; reqUser = usr;
    expQ.push_back(predict(va, usr, tag));
    @(negedge clk);
    cfgWrEn = 1'b0;
    mdlWrite(sel, d);
  endtask

  // Monitor: pops the scoreboard each time a result appears.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, $sformatf("R2 unexpected result va=%h got valid=1 exp valid=0", rspVaddr));
      end else begin
        mItem = expQ.pop_front();
        check(rspPaddr == mItem.paddr && rspVaddr == mItem.vaddr && rspPageNum == mItem.pnum &&
              rspPageReq == mItem.pg && rspFault == mItem.flt,
              $sformatf("%s va=%h got pa=%h va=%h pn=%h pg=%b f=%b exp pa=%h va=%h pn=%h pg=%b f=%b",
                        mItem.tag, mItem.vaddr, rspPaddr, rspVaddr, rspPageNum, rspPageReq, rspFault,
                        mItem.paddr, mItem.vaddr, mItem.pnum, mItem.pg, mItem.flt));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, $sformatf("R1 reset rspValid got %b exp 0", rspValid));
    check(reqReady == 1'b0, $sformatf("R1 reset reqReady got %b exp 0", reqReady));
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, $sformatf("R1 ready after reset got %b exp 1", reqReady));
    check(rspValid == 1'b0, $sformatf("R1 idle rspValid got %b exp 0", rspValid));

    // R1 / R8: identity map, kernel reaches every segment
    for (int s = 0; s < 16; s++) sendReq({4'(s), 28'h0123ABC}, 1'b0, "R1_R8 identity");
    idle();

    // R4: user ceiling; R3 user access below it
    sendReq(32'hAFFF_FFFC, 1'b1, "R3 user top of allowed");
    sendReq(32'hB000_0000, 1'b1, "R4 user seg B");
    sendReq(32'hF123_4567, 1'b1, "R4 user seg F");
    idle();

    // R6 / R3: high bases {f0 e8 d0 c4 bB a0 90 80}
    cfgWrite(2'd2, 32'h0804_B000);
    sendReq(32'hC000_0000, 1'b0, "R3_R6 seg C base 4");
    sendReq(32'hE123_4568, 1'b0, "R3_R6 seg E base 8");
    sendReq(32'hB000_0010, 1'b0, "R3_R6 seg B base B");
    sendReq(32'h9000_0004, 1'b0, "R3_R6 seg 9 base 0");
    idle();

    // R6: low bases, segment 4 stays unity
    cfgWrite(2'd1, 32'h0004_0000);
    sendReq(32'h4000_1234, 1'b0, "R6 seg 4 unity");
    sendReq(32'h1ABC_DEF0, 1'b1, "R6 seg 1 base 0 user");
    idle();

    // R5: segments 0..3 and D paged
    cfgWrite(2'd0, 32'h0000_200F);
    sendReq(32'hD004_000C, 1'b0, "R5 kernel paged D");
    sendReq(32'h2000_2000, 1'b1, "R5 user paged 2");
    sendReq(32'hD000_0000, 1'b1, "R4 user fault beats paging");
    sendReq(32'h5555_5555, 1'b0, "R9 linear seg 5 vpn zero");
    idle();

    // R7: same-edge write uses old mode mask, next request the new one
    cfgAndReq(2'd0, 32'h0000_0000, 32'hD004_000C, 1'b0, "R7 same edge old cfg");
    sendReq(32'hD004_000C, 1'b0, "R7 next edge new cfg");
    idle();

    // R10: reserved selector changes nothing
    cfgWrite(2'd3, 32'hFFFF_FFFF);
    sendReq(32'h4000_0040, 1'b0, "R10 base kept");
    sendReq(32'h0000_4000, 1'b0, "R10 mode kept");
    idle();

    // R2: back-to-back stream
    for (int k = 0; k < 8; k++) sendReq(32'h1357_9BDF + 32'(k) * 32'h2100_0000, 1'(k & 1), "R2 burst");
    idle();
    idle();

    check(expQ.size() == 0, $sformatf("R2 pending results got %0d exp 0", expQ.size()));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule